// File: doc/BRIEF.md
# Two-Wire Register-Bank Slave

This block is a two-wire serial slave, running entirely in the system clock domain, that lets an external host read and write a bank of 128 byte-wide registers. Both bus lines are oversampled: each passes through a two-stage synchroniser and a glitch filter. START and STOP are recognised as data edges that occur while the clock line is high. The slave compares the 7-bit address byte against its own address and then services write or read transfers. The data line is driven through a drive-low enable. The clock line is never driven, because the slave does not stretch the clock.

In a write transfer, the first data byte sets an internal byte pointer. The lower seven bits of that byte select a register, and the top bit freezes the pointer. Each later byte of a write, and every byte of a read, uses the pointer. The pointer then moves forward by one, but it stays where it is if the freeze bit is set, and it never moves past the last register. A STOP clears the pointer. A repeated START keeps it, so a host can set the pointer in a write and then switch to a read without losing its place. The bottom four bits of the slave's address are taken from strap inputs that are sampled while reset is held.

Top module: `twi_regbank_slave`

## Requirements
- R1: The device address is {3'b000, strap_i[3:0]}, where strap_i is the value present on the last clock edge before rst_n rises; a later change on strap_i does not alter the address.
- R2: Bits travel most significant bit first. Bit 0 of the address byte (the eighth bit) selects a read when it is 1 and a write when it is 0.
- R3: The first data byte of a write transfer loads the pointer. Bits 6:0 become the register index, and bit 7 becomes the freeze flag.
- R4: With the freeze flag at 0, each later written or read byte uses the register at the pointer and then moves the pointer up by one. With the flag at 1, every byte uses the same register.
- R5: Once the pointer reaches 127 it stays there, and every further byte reads or writes register 127 until a STOP.
- R6: A STOP that follows a matching address byte sets the pointer to 0. A START or repeated START leaves the pointer unchanged.
- R7: A read transfer that begins after a STOP returns register 0 first.
- R8: After an address byte that does not match, the slave gives no acknowledge, writes no register and never pulls the data line, until the next START that carries a matching address.
- R9: The slave pulls the data line low during the ninth clock of a matching address byte and of every written byte. In a read transfer it releases the data line during the ninth clock, and it stops sending when the host leaves the line high on that clock (no acknowledge).
- R10: After reset, every register reads 0 and the slave does not pull the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus sampling is done on it |
| rst_n | input | 1 | Active-low synchronous reset; the strap value is taken while it is low |
| strap_i | input | 4 | Board straps giving the low four address bits |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull the data line low; 0 = release it |

## Verification
Several kinds of transfer are run against a behavioural model of the register bank and the pointer, and the data-line drive is compared on every clock of each bit's high phase:
- Plain multi-byte writes followed by a read after a STOP show that the pointer is cleared by STOP and not by START.
- A pointer write followed by a repeated-START read separates the two ways a transfer can end.
- Transfers with the freeze bit set, and transfers that run past index 126, separate freezing from saturation.
- Transfers with a wrong address, including one whose top bits are non-zero and one that matches only the strap value applied after reset, must leave the line released and the registers untouched.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int PTR_W = 7;
  localparam int REG_COUNT = 1 << PTR_W;
  localparam int STRAP_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } twi_state_e;

  // Pointer step after a byte access: hold when frozen, stop at the top.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                input logic frozen);
    if (frozen || p == PTR_W'(REG_COUNT - 1)) return p;
    return p + PTR_W'(1);
  endfunction
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        cnt_q <= '0;
        out_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/twi_reg_array.sv
module twi_reg_array #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twi_regbank_slave.sv
module twi_regbank_slave
  import twi_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o
);
  logic [1:0] raw_lines, filt_lines;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    twi_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[g]), .line_o(filt_lines[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  logic scl_rise, scl_fall, start_ev, stop_ev;
  twi_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_state_e         state_q;
  logic [3:0]         cnt_q;
  logic [7:0]         sh_q;
  logic [PTR_W-1:0]   ptr_q;
  logic               frz_q, first_q, addressed_q, rw_q, nack_q, pull_q;
  logic [STRAP_W-1:0] strap_q;
  logic [7:0]         rdata;

  // Straps are followed while reset is held, frozen once it is released.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end

  logic byte_end, addr_hit, we, rd_stb;
  assign byte_end = scl_fall && (cnt_q == 4'd8);
  assign addr_hit = (sh_q[7:1] == {3'b000, strap_q});
  assign we       = (state_q == ST_WDAT) && byte_end && !first_q;
  assign rd_stb   = scl_fall && (((state_q == ST_AACK) && rw_q) ||
                                 ((state_q == ST_RACK) && !nack_q));

  twi_reg_array #(.AW(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(ptr_q), .wdata_i(sh_q),
    .raddr_i(ptr_q), .rdata_o(rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '0;
      ptr_q       <= '0;
      frz_q       <= 1'b0;
      first_q     <= 1'b0;
      addressed_q <= 1'b0;
      rw_q        <= 1'b0;
      nack_q      <= 1'b0;
      pull_q      <= 1'b0;
    end else if (stop_ev) begin
      state_q     <= ST_IDLE;
      pull_q      <= 1'b0;
      addressed_q <= 1'b0;
      if (addressed_q) ptr_q <= '0;
    end else if (start_ev) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      pull_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_f};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_end) begin
            cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                addressed_q <= 1'b1;
                rw_q        <= sh_q[0];
                first_q     <= ~sh_q[0];
                pull_q      <= 1'b1;
                state_q     <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              if (first_q) begin
                ptr_q <= sh_q[PTR_W-1:0];
                frz_q <= sh_q[7];
              end else begin
                ptr_q <= ptr_step(ptr_q, frz_q);
              end
              first_q <= 1'b0;
              pull_q  <= 1'b1;
              state_q <= ST_WACK;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            pull_q  <= 1'b0;
            state_q <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_RACK;
            end else begin
              pull_q <= ~sh_q[7];
              sh_q   <= {sh_q[6:0], 1'b0};
              cnt_q  <= cnt_q + 4'd1;
            end
          end
        end
        ST_AACK, ST_RACK: begin
          if (scl_rise && state_q == ST_RACK) nack_q <= sda_f;
          if (scl_fall) begin
            if (rd_stb) begin
              pull_q  <= ~rdata[7];
              sh_q    <= {rdata[6:0], 1'b0};
              cnt_q   <= 4'd1;
              ptr_q   <= ptr_step(ptr_q, frz_q);
              state_q <= ST_RDAT;
            end else if (state_q == ST_AACK) begin
              pull_q  <= 1'b0;
              state_q <= ST_WDAT;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull_q;

  AST_STOP_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && addressed_q) |=> (ptr_q == '0)); // R6
  AST_START_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> $stable(ptr_q)); // R6
  AST_PTR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr_q == PTR_W'(REG_COUNT - 1)) && (we || rd_stb)) |=> (ptr_q == PTR_W'(REG_COUNT - 1))); // R5
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && (we || rd_stb)) |=> $stable(ptr_q)); // R4
  AST_WRITE_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> addressed_q); // R8
  AST_PULL_AT_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> $past(scl_fall || start_ev || stop_ev)); // R9
endmodule

// File: tb/sim_twi_regbank_slave.sv
module sim_twi_regbank_slave;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [3:0] strap = 4'hA;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  wire        pull;
  wire        sda_bus = sda_m & ~pull;

  twi_regbank_slave u0 (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(pull)
  );

  localparam int Q = 10;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] mem [128];
  int         ptr = 0;
  bit         frz = 0, addressed = 0;
  logic [3:0] strap_lat;
  logic [7:0] wq [$];

  logic exp_pull = 1'b0;
  bit   win_on = 0, win_bad = 0;
  always @(negedge clk) if (win_on && pull !== exp_pull) win_bad = 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input bit m, input bit ep, input string tag, output bit line);
    sda_m = m;
    wait_clk(Q);
    exp_pull = ep; win_bad = 0; win_on = 1;
    scl_m = 1'b1;
    wait_clk(Q);
    line = sda_bus;
    wait_clk(Q);
    win_on = 0;
    check(!win_bad, tag, int'(!ep ^ win_bad), int'(ep));
    scl_m = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0;
  endtask

  task automatic do_stop();
    wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
    if (addressed) ptr = 0;
    addressed = 0;
  endtask

  function automatic void advance();
    if (!frz && ptr < 127) ptr++;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit ack, input string tag);
    bit line;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, tag, line);
    bus_bit(1'b1, ack, tag, line);
    check(line == !ack, tag, line, !ack);
  endtask

  task automatic recv_byte(input logic [7:0] e, input bit mack, input string tag);
    bit line;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, ~e[i], tag, line);
      got[i] = line;
    end
    bus_bit(~mack, 1'b0, tag, line);
    check(got == e, tag, got, e);
  endtask

  task automatic xfer_write(input logic [6:0] dev, input bit stop, input string tag);
    bit hit = (dev == {3'b000, strap_lat});
    do_start();
    send_byte({dev, 1'b0}, hit, hit ? "R9" : "R8");
    if (hit) addressed = 1;
    foreach (wq[k]) begin
      send_byte(wq[k], hit, hit ? (k == 0 ? "R3" : tag) : "R8");
      if (hit) begin
        if (k == 0) begin
          ptr = wq[k][6:0];
          frz = wq[k][7];
        end else begin
          mem[ptr] = wq[k];
          advance();
        end
      end
    end
    if (stop) do_stop();
  endtask

  task automatic xfer_read(input logic [6:0] dev, input int n, input bit stop, input string tag);
    bit hit = (dev == {3'b000, strap_lat});
    do_start();
    send_byte({dev, 1'b1}, hit, hit ? "R2" : "R8");
    if (hit) addressed = 1;
    for (int k = 0; k < n; k++) begin
      recv_byte(hit ? mem[ptr] : 8'hFF, k < n - 1, hit ? tag : "R8");
      if (hit) advance();
    end
    if (stop) do_stop();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    wait_clk(5);
    strap_lat = strap;
    rst_n = 1'b1;
    wait_clk(2);
    strap = 4'h5;
    check(pull == 1'b0, "R10", pull, 0);

    xfer_read(7'h0A, 2, 1, "R10");
    wq = {8'h10, 8'h11, 8'h22, 8'h33};
    xfer_write(7'h0A, 1, "R4");
    wq = {8'h10};
    xfer_write(7'h0A, 0, "R6");
    xfer_read(7'h0A, 3, 1, "R6");
    wq = {8'h00, 8'h5A};
    xfer_write(7'h0A, 1, "R4");
    xfer_read(7'h0A, 2, 1, "R7");
    wq = {8'hA0, 8'h01, 8'h02, 8'h03};
    xfer_write(7'h0A, 1, "R4");
    wq = {8'h20};
    xfer_write(7'h0A, 0, "R3");
    xfer_read(7'h0A, 2, 1, "R4");
    wq = {8'hA0};
    xfer_write(7'h0A, 0, "R3");
    xfer_read(7'h0A, 2, 1, "R4");
    wq = {8'h7E, 8'hAA, 8'hBB, 8'hCC};
    xfer_write(7'h0A, 1, "R5");
    wq = {8'h7E};
    xfer_write(7'h0A, 0, "R3");
    xfer_read(7'h0A, 4, 1, "R5");
    wq = {8'h00, 8'hEE};
    xfer_write(7'h05, 1, "R1");
    wq = {8'h00, 8'hEE};
    xfer_write(7'h1A, 1, "R1");
    xfer_read(7'h05, 1, 1, "R8");
    xfer_read(7'h0A, 1, 1, "R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule